// File: doc/BRIEF.md
# Multichannel Voltage Threshold Fault Monitor

This block walks a conversion multiplexer round-robin over a set of monitored supply channels. At each stop it raises a request to an external converter and holds the channel index steady. It then waits for a done strobe that carries a 10-bit sample. The sample is stored in that channel's result slot and tested against the channel's own upper and lower limits. A per-channel enable decides whether a violation becomes a visible fault. A second per-channel enable decides whether that fault fires a one-shot trigger toward a nonvolatile logger.

Scanning runs only while the external scan enable is high and the software stop bit is low. While the chip is still booting, the block masks every channel, so no fault, violation or log event can arise. After the logger has been triggered once, a write-protect flag holds off any further triggers until a clear pulse arrives. A conversion that does not finish within a configurable number of cycles is abandoned and the scan moves on. The channel count is a parameter: twelve by default, and eight for the smaller variant.

Top module: `vmon_scan_top`

## Requirements
- R1: After reset the scan starts at channel 0 and steps up by one after each finished or abandoned conversion. After channel `min(last_ch, NUM_CH-1)` it wraps back to 0. `adc_ch` holds steady while `adc_req` stays high.
- R2: `adc_req` is high only while `scan_en`=1 and `soft_stop`=0. If either condition fails during a conversion, `adc_req` drops on the next cycle, the conversion is discarded and the channel index does not advance.
- R3: A cycle with `adc_req`=1 and `adc_done`=1 writes `adc_data` into bits `[10*c+9:10*c]` of `results`, where c is `adc_ch`. The new value is visible from the next cycle on.
- R4: Overvoltage means sample > upper limit, and undervoltage means sample < lower limit. A sample equal to either limit is in range. The limits of channel c sit at bits `[10*c+9:10*c]` of `ov_lim` and `uv_lim`.
- R5: Each conversion of channel c sets `fault[c]` to (violation AND `fault_en[c]`). The bit therefore clears again after an in-range sample, or when the sample arrives while the enable is 0.
- R6: While `boot_busy`=1, `fault` and all violation state are cleared from the next cycle on. `all_ok` is 0, and no log trigger can occur.
- R7: `all_ok` is 1 exactly when `boot_busy`=0 and no channel's most recent conversion since the last boot or reset was out of range.
- R8: A conversion that produces a fault on channel c while `log_en[c]`=1 and `wp_flag`=0 pulses `log_pulse` for one cycle with `log_ch`=c. It sets `wp_flag` in the same cycle.
- R9: While `wp_flag`=1 no further `log_pulse` occurs. A one-cycle `wp_clr` pulse clears `wp_flag` on the next cycle.
- R10: If `adc_done` does not arrive, `adc_req` stays high for exactly `CONV_TMO` cycles and then drops. The result slot is left unchanged and the scan moves on to the next channel.
- R11: After a finished conversion, `adc_req` is low for exactly one cycle before the next request, provided scanning is still allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | External scan enable |
| soft_stop | input | 1 | Software stop bit; 1 halts scanning |
| boot_busy | input | 1 | High while boot-up is in progress; masks all channels |
| adc_done | input | 1 | Converter finished; `adc_data` valid |
| adc_data | input | 10 | Converted sample |
| ov_lim | input | NUM_CH*10 | Upper limits, 10 bits per channel |
| uv_lim | input | NUM_CH*10 | Lower limits, 10 bits per channel |
| fault_en | input | NUM_CH | Per-channel enable for fault generation |
| log_en | input | NUM_CH | Per-channel enable for log triggering |
| last_ch | input | CH_W | Highest channel in the scan loop |
| wp_clr | input | 1 | Clears the write-protect flag |
| adc_req | output | 1 | Conversion request |
| adc_ch | output | CH_W | Channel currently selected |
| results | output | NUM_CH*10 | Last sample of every channel |
| fault | output | NUM_CH | Per-channel fault flags |
| all_ok | output | 1 | Every channel within its limits |
| log_pulse | output | 1 | One-cycle trigger toward the fault logger |
| log_ch | output | CH_W | Channel that caused the last trigger |
| wp_flag | output | 1 | Log write-protect flag |

## Verification
Samples are drawn at random across the full 10-bit range, and also placed exactly on each limit and one step beyond it. This separates strict from non-strict comparison and shows an upper-limit error apart from a lower-limit error. Fault and log enables are toggled at random between conversions, so a raw violation can be seen to stay hidden when the enable is off, and to fire the logger only once until the clear pulse. Directed runs stop the scan in mid-conversion through each gating input, hold back the done strobe until the timeout, and set the loop limit both below and beyond the channel count. These runs separate a discarded conversion from an abandoned one, and a correct wrap point from an off-by-one.

// File: rtl/vmon_pkg.sv
`timescale 1ns/1ps
package vmon_pkg;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_CONV = 1'b1
    } scan_st_e;

    // strict comparisons: equal to a limit counts as in range
    function automatic logic is_over(input logic [9:0] smp, input logic [9:0] lim);
        return smp > lim;
    endfunction

    function automatic logic is_under(input logic [9:0] smp, input logic [9:0] lim);
        return smp < lim;
    endfunction

endpackage

// File: rtl/vmon_seq.sv
`timescale 1ns/1ps
module vmon_seq
    import vmon_pkg::*;
#(
    parameter int NUM_CH   = 12,
    parameter int CH_W     = 4,
    parameter int CONV_TMO = 1040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CH_W-1:0] last_ch,
    input  logic            adc_done,
    output logic            adc_req,
    output logic [CH_W-1:0] adc_ch,
    output logic            cap
);
    localparam int TMO_W = $clog2(CONV_TMO + 1);
    localparam logic [CH_W-1:0] TOP_CH  = CH_W'(NUM_CH - 1);
    localparam logic [TMO_W-1:0] TMO_END = TMO_W'(CONV_TMO - 1);

    typedef struct packed {
        scan_st_e        st;
        logic [CH_W-1:0] ch;
        logic [TMO_W-1:0] tmr;
    } seq_s;

    seq_s seq_d, seq_q;
    logic [CH_W-1:0] wrap_lim;
    logic [CH_W-1:0] ch_nxt;

    always_comb begin
        seq_d    = seq_q;
        wrap_lim = (last_ch > TOP_CH) ? TOP_CH : last_ch;
        ch_nxt   = (seq_q.ch >= wrap_lim) ? '0 : CH_W'(seq_q.ch + 1'b1);
        cap      = 1'b0;
        unique case (seq_q.st)
            SCAN_IDLE: begin
                if (run) begin
                    seq_d.st  = SCAN_CONV;
                    seq_d.tmr = '0;
                end
            end
            SCAN_CONV: begin
                if (!run) begin
                    seq_d.st = SCAN_IDLE;
                end else if (adc_done) begin
                    cap      = 1'b1;
                    seq_d.st = SCAN_IDLE;
                    seq_d.ch = ch_nxt;
                end else if (seq_q.tmr == TMO_END) begin
                    seq_d.st = SCAN_IDLE;
                    seq_d.ch = ch_nxt;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            default: seq_d.st = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SCAN_IDLE, ch: '0, tmr: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign adc_req = (seq_q.st == SCAN_CONV);
    assign adc_ch  = seq_q.ch;

    // R1: channel held for the whole request
    p_ch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req ##1 adc_req |-> $stable(adc_ch));
    // R1: index never leaves the channel range
    p_ch_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_ch <= TOP_CH);
    // R2: no request without permission
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !adc_req);
    // R11: one idle cycle after a finished conversion
    p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && adc_done) |=> !adc_req);

endmodule

// File: rtl/vmon_cmp.sv
`timescale 1ns/1ps
module vmon_cmp
    import vmon_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] smp,
    input  logic [RES_W-1:0] hi_lim,
    input  logic [RES_W-1:0] lo_lim,
    output logic             over,
    output logic             under
);
    always_comb begin
        over  = is_over(smp, hi_lim);
        under = is_under(smp, lo_lim);
    end
endmodule

// File: rtl/vmon_flags.sv
`timescale 1ns/1ps
module vmon_flags #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4,
    parameter int RES_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic [CH_W-1:0]         cap_ch,
    input  logic [RES_W-1:0]        cap_val,
    input  logic                    over,
    input  logic                    under,
    input  logic                    boot_busy,
    input  logic [NUM_CH-1:0]       fault_en,
    input  logic [NUM_CH-1:0]       log_en,
    input  logic                    wp_clr,
    output logic [NUM_CH*RES_W-1:0] results,
    output logic [NUM_CH-1:0]       fault,
    output logic                    all_ok,
    output logic                    log_pulse,
    output logic [CH_W-1:0]         log_ch,
    output logic                    wp_flag
);
    typedef struct packed {
        logic [NUM_CH-1:0][RES_W-1:0] res;
        logic [NUM_CH-1:0]            viol;
        logic [NUM_CH-1:0]            flt;
        logic                         trig;
        logic [CH_W-1:0]              lch;
        logic                         wp;
    } flag_s;

    flag_s fl_d, fl_q;
    logic  bad;
    logic  flt_hit;

    always_comb begin
        fl_d    = fl_q;
        fl_d.trig = 1'b0;
        bad     = over | under;
        flt_hit = bad & fault_en[cap_ch];
        if (wp_clr) begin
            fl_d.wp = 1'b0;
        end
        if (cap) begin
            fl_d.res[cap_ch] = cap_val;
            if (!boot_busy) begin
                fl_d.viol[cap_ch] = bad;
                fl_d.flt[cap_ch]  = flt_hit;
                if (flt_hit && log_en[cap_ch] && !fl_q.wp) begin
                    fl_d.trig = 1'b1;
                    fl_d.lch  = cap_ch;
                    fl_d.wp   = 1'b1;
                end
            end
        end
        if (boot_busy) begin
            fl_d.viol = '0;
            fl_d.flt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_res
        assign results[gi*RES_W +: RES_W] = fl_q.res[gi];
    end

    assign fault     = fl_q.flt;
    assign all_ok    = !boot_busy && (fl_q.viol == '0);
    assign log_pulse = fl_q.trig;
    assign log_ch    = fl_q.lch;
    assign wp_flag   = fl_q.wp;

    // R6: boot masks every fault
    p_boot_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_busy |=> (fault == '0));
    // R8: trigger always leaves the protect flag set
    p_trig_sets_wp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        log_pulse |-> wp_flag);
    // R9: no trigger while protected
    p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        log_pulse |-> !$past(wp_flag));
    // R9: clear pulse without a new trigger drops the flag
    p_wp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_clr && !cap) |=> !wp_flag);
    // R8: trigger is a single-cycle pulse
    p_trig_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        log_pulse |=> !log_pulse);

endmodule

// File: rtl/vmon_scan_top.sv
`timescale 1ns/1ps
module vmon_scan_top #(
    parameter int NUM_CH   = 12,
    parameter int RES_W    = 10,
    parameter int CONV_TMO = 1040,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_en,
    input  logic                    soft_stop,
    input  logic                    boot_busy,
    input  logic                    adc_done,
    input  logic [RES_W-1:0]        adc_data,
    input  logic [NUM_CH*RES_W-1:0] ov_lim,
    input  logic [NUM_CH*RES_W-1:0] uv_lim,
    input  logic [NUM_CH-1:0]       fault_en,
    input  logic [NUM_CH-1:0]       log_en,
    input  logic [CH_W-1:0]         last_ch,
    input  logic                    wp_clr,
    output logic                    adc_req,
    output logic [CH_W-1:0]         adc_ch,
    output logic [NUM_CH*RES_W-1:0] results,
    output logic [NUM_CH-1:0]       fault,
    output logic                    all_ok,
    output logic                    log_pulse,
    output logic [CH_W-1:0]         log_ch,
    output logic                    wp_flag
);
    logic             run;
    logic             cap;
    logic             over;
    logic             under;
    logic [RES_W-1:0] hi_sel;
    logic [RES_W-1:0] lo_sel;

    assign run    = scan_en && !soft_stop;
    assign hi_sel = ov_lim[int'(adc_ch)*RES_W +: RES_W];
    assign lo_sel = uv_lim[int'(adc_ch)*RES_W +: RES_W];

    vmon_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CONV_TMO(CONV_TMO)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .last_ch  (last_ch),
        .adc_done (adc_done),
        .adc_req  (adc_req),
        .adc_ch   (adc_ch),
        .cap      (cap)
    );

    vmon_cmp #(.RES_W(RES_W)) cmp_i (
        .smp    (adc_data),
        .hi_lim (hi_sel),
        .lo_lim (lo_sel),
        .over   (over),
        .under  (under)
    );

    vmon_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_ch    (adc_ch),
        .cap_val   (adc_data),
        .over      (over),
        .under     (under),
        .boot_busy (boot_busy),
        .fault_en  (fault_en),
        .log_en    (log_en),
        .wp_clr    (wp_clr),
        .results   (results),
        .fault     (fault),
        .all_ok    (all_ok),
        .log_pulse (log_pulse),
        .log_ch    (log_ch),
        .wp_flag   (wp_flag)
    );

    // R3: a stored sample appears in the selected slot
    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && adc_done && run) |=>
            results[int'($past(adc_ch))*RES_W +: RES_W] == $past(adc_data));

endmodule

// File: tb/vmon_scan_top_tb_top.sv
`timescale 1ns/1ps
module vmon_scan_top_tb_top;
    localparam int NUM_CH = 12;
    localparam int RES_W  = 10;
    localparam int TMO    = 16;
    localparam int CH_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b1, soft_stop = 1'b0, boot_busy = 1'b0;
    logic adc_done = 1'b0;
    logic [RES_W-1:0] adc_data = '0;
    logic [NUM_CH*RES_W-1:0] ov_lim = '0, uv_lim = '0;
    logic [NUM_CH-1:0] fault_en = '0, log_en = '0;
    logic [CH_W-1:0] last_ch = CH_W'(NUM_CH - 1);
    logic wp_clr = 1'b0;
    logic adc_req;
    logic [CH_W-1:0] adc_ch, log_ch;
    logic [NUM_CH*RES_W-1:0] results;
    logic [NUM_CH-1:0] fault;
    logic all_ok, log_pulse, wp_flag;

    int n_chk = 0, n_fail = 0, cyc = 0, exp_ch = 0;
    logic [RES_W-1:0] m_res [NUM_CH];
    bit m_viol [NUM_CH];
    bit m_flt [NUM_CH];
    bit m_wp = 0;

    vmon_scan_top #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CONV_TMO(TMO)) dut_i (.*);

    always #4 clk = ~clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int next_ch(input int c);
        int lim = (int'(last_ch) > NUM_CH - 1) ? NUM_CH - 1 : int'(last_ch);
        return (c >= lim) ? 0 : c + 1;
    endfunction

    function automatic logic [NUM_CH-1:0] exp_fault();
        logic [NUM_CH-1:0] v;
        for (int i = 0; i < NUM_CH; i++) v[i] = m_flt[i];
        return v;
    endfunction

    function automatic bit exp_ok();
        bit any = 0;
        for (int i = 0; i < NUM_CH; i++) any |= m_viol[i];
        return !boot_busy && !any;
    endfunction

    task automatic wait_req();
        int g = 0;
        while (!adc_req && g < 200) begin
            @(negedge clk);
            g++;
        end
        chk(adc_req == 1'b1, "R2 request expected while scanning allowed", adc_req, 1);
    endtask

    task automatic conv(input logic [RES_W-1:0] val, input int dly);
        int c;
        bit bad, trig;
        logic [RES_W-1:0] hi, lo;
        wait_req();
        chk(int'(adc_ch) == exp_ch, "R1 scan order", adc_ch, exp_ch);
        c = int'(adc_ch);
        repeat (dly) @(negedge clk);
        hi = ov_lim[c*RES_W +: RES_W];
        lo = uv_lim[c*RES_W +: RES_W];
        adc_data = val;
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        bad = (val > hi) || (val < lo);   // R4 strict limits
        trig = 0;
        m_res[c] = val;
        if (!boot_busy) begin
            m_viol[c] = bad;
            m_flt[c] = bad && fault_en[c];
            if (m_flt[c] && log_en[c] && !m_wp) begin
                trig = 1;
                m_wp = 1;
            end
        end
        exp_ch = next_ch(c);
        chk(results[c*RES_W +: RES_W] == val, "R3 result slot", results[c*RES_W +: RES_W], val);
        chk(fault == exp_fault(), "R4/R5 fault flags", fault, exp_fault());
        chk(all_ok == exp_ok(), "R7 all-in-range", all_ok, exp_ok());
        chk(log_pulse == trig, "R8 log trigger", log_pulse, trig);
        if (trig) chk(int'(log_ch) == c, "R8 log channel", log_ch, c);
        chk(wp_flag == m_wp, "R9 write-protect flag", wp_flag, m_wp);
        chk(adc_req == 1'b0, "R11 idle gap after conversion", adc_req, 0);
    endtask

    task automatic clear_wp();
        wp_clr = 1'b1;
        @(negedge clk);
        wp_clr = 1'b0;
        m_wp = 0;
        chk(wp_flag == 1'b0, "R9 clear pulse", wp_flag, 0);
    endtask

    task automatic set_lim(input int c, input logic [RES_W-1:0] hi, input logic [RES_W-1:0] lo);
        ov_lim[c*RES_W +: RES_W] = hi;
        uv_lim[c*RES_W +: RES_W] = lo;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_CH; i++) begin
            set_lim(i, 10'd800, 10'd200);
            m_res[i] = '0;
            m_viol[i] = 0;
            m_flt[i] = 0;
        end
        fault_en = '1;
        repeat (4) @(negedge clk);
        chk(adc_req == 0 && fault == '0 && wp_flag == 0 && log_pulse == 0,
            "R1 reset state", {adc_req, fault, wp_flag, log_pulse}, 0);
        chk(results == '0, "R3 reset results", results, 0);
        rst_n = 1'b1;

        // limits and strictness
        conv(10'd500, 0);
        conv(10'd801, 2);   // R4 over
        conv(10'd800, 1);   // R4 equal high is in range
        conv(10'd199, 0);   // R4 under
        conv(10'd200, 3);   // R4 equal low is in range
        fault_en[5] = 1'b0;
        conv(10'd1000, 0);  // R5 violation with fault disabled
        fault_en[5] = 1'b1;

        // logging and protection
        log_en = '1;
        conv(10'd900, 0);   // R8 trigger
        conv(10'd5, 0);     // R9 blocked
        clear_wp();
        conv(10'd950, 1);   // R8 again after clear
        clear_wp();

        // R10 timeout
        begin
            int c, n;
            logic [RES_W-1:0] old;
            wait_req();
            c = int'(adc_ch);
            old = results[c*RES_W +: RES_W];
            n = 0;
            while (adc_req && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk(n == TMO, "R10 request length on timeout", n, TMO);
            chk(results[c*RES_W +: RES_W] == old, "R10 result untouched", results[c*RES_W +: RES_W], old);
            exp_ch = next_ch(c);
        end
        conv(10'd400, 0);

        // R2 gating by each input
        for (int k = 0; k < 2; k++) begin
            wait_req();
            if (k == 0) soft_stop = 1'b1; else scan_en = 1'b0;
            @(negedge clk);
            chk(adc_req == 0, "R2 request drops when gated", adc_req, 0);
            repeat (4) @(negedge clk);
            chk(adc_req == 0, "R2 stays idle while gated", adc_req, 0);
            soft_stop = 1'b0;
            scan_en = 1'b1;
            conv(10'd300, 0);   // same channel, not advanced
        end

        // R6 boot masking
        boot_busy = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) begin
            m_viol[i] = 0;
            m_flt[i] = 0;
        end
        chk(fault == '0 && all_ok == 0, "R6 boot clears faults", {fault, all_ok}, 0);
        conv(10'd1023, 0);
        chk(log_pulse == 0 && fault == '0, "R6 no fault or log in boot", {log_pulse, fault}, 0);
        conv(10'd0, 1);
        boot_busy = 1'b0;
        @(negedge clk);
        chk(all_ok == 1, "R7 in range after boot", all_ok, 1);

        // R1 wrap below and beyond channel count
        last_ch = 4'd3;
        for (int i = 0; i < 6; i++) conv(10'd500, 0);
        last_ch = 4'd15;
        for (int i = 0; i < 14; i++) conv(10'd500, 0);

        // random phase
        for (int it = 0; it < 300; it++) begin
            logic [RES_W-1:0] v;
            int c = exp_ch;
            int sel = $urandom_range(0, 5);
            if ($urandom_range(0, 7) == 0) begin
                logic [RES_W-1:0] lo = RES_W'($urandom_range(0, 500));
                set_lim($urandom_range(0, NUM_CH - 1), RES_W'($urandom_range(500, 1023)), lo);
            end
            if ($urandom_range(0, 5) == 0) fault_en = NUM_CH'($urandom);
            if ($urandom_range(0, 5) == 0) log_en = NUM_CH'($urandom);
            if ($urandom_range(0, 9) == 0) clear_wp();
            case (sel)
                0: v = ov_lim[c*RES_W +: RES_W];
                1: v = ov_lim[c*RES_W +: RES_W] + 1'b1;
                2: v = uv_lim[c*RES_W +: RES_W];
                3: v = uv_lim[c*RES_W +: RES_W] - 1'b1;
                default: v = RES_W'($urandom);
            endcase
            conv(v, $urandom_range(0, 6));
        end
        report();
    end
endmodule